// File: doc/BRIEF.md
# Serial Bit Error Rate Tester

This block is a one-bit-per-clock bit error rate tester. A transmit pattern generator sends a selected test pattern, and a receive checker compares the incoming line against the same pattern. The pattern is either a pseudorandom sequence or a fixed pattern. Each direction can invert its data on its own, so the tester can work across a line that inverts polarity.

The receive side uses its own pattern register and seeds it from the incoming bits. It reports lock once it has seen a run of error-free bits, and it drops lock when errors cluster inside a fixed window. While the receiver is locked, two saturating counters track the bits received and the bit errors.

A host controls the block through a byte-wide register port. A rising edge on the load bit copies both counters into holding registers and clears them. A rising edge on the resync bit makes the receiver reacquire the pattern.

Both data paths use valid/ready. The transmit output keeps `tx_valid` high from the first cycle after reset. It holds `tx_bit` steady while `tx_ready` is low and moves to the next pattern bit after each cycle in which `tx_valid && tx_ready`. The receive input has `rx_ready` tied high and never pushes back. A bit is taken on every cycle in which `rx_valid` is high.

Top module: `bert_engine`

## Requirements
- R1: After reset, every register address reads 0, `in_sync` is 0, `tx_valid` is 1 and `rx_ready` is 1.
- R2: Address 0 is the control byte. Bit 6 is transmit invert, bit 5 is receive invert, bits 4..2 are the pattern select, bit 1 is load and bit 0 is resync. Bit 7 always reads 0, and the other bits read back as written.
- R3: Pattern select encodings: 0 is a 15-stage PRBS with b[t]=b[t-15]^b[t-14], 1 is a 20-stage PRBS with b[t]=b[t-20]^b[t-17], 2 is an 11-stage PRBS with b[t]=b[t-11]^b[t-9], 3 is a 9-stage PRBS with b[t]=b[t-9]^b[t-5], 4 is all ones, 5 is alternating ones and zeros, and 6 and 7 are all zeros. A PRBS never stays stuck at all zeros.
- R4: When transmit invert is 1, every transmitted bit is the complement of the pattern bit.
- R5: While `tx_ready` is low, `tx_bit` and `tx_valid` hold their values, and the pattern does not advance.
- R6: When receive invert is 1, received bits are complemented before checking. If the transmit and receive inversions match on a looped-back line, the receiver locks. If they differ on a PRBS, it never locks.
- R7: After a forced resync on a clean, aligned stream, `in_sync` rises on exactly the 32nd accepted bit.
- R8: While locked, the receiver stays locked with 5 errors in a 64-bit window, which begins at lock. It drops lock on the 6th error in that window.
- R9: A 0-to-1 write of the resync bit clears `in_sync` one cycle later. Writing the bit as 1 again while it is already 1 has no effect.
- R10: The bit counter counts accepted bits and the error counter counts mismatches, but only while locked.
- R11: A 0-to-1 write of the load bit copies both counters to the holding registers and clears the counters. Writing the bit as 1 again while it is already 1 does not reload. A bit accepted on the same cycle as the load lands in the cleared counter.
- R12: Both counters saturate at all ones and never wrap.
- R13: The bit count is read little-endian at addresses 1 to BIT_CNT_W/8. The error count follows at the next ERR_CNT_W/8 addresses. Reads have no side effects, and the holding registers change only on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| tx_valid | output | 1 | Transmit bit valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_bit | output | 1 | Transmit pattern bit |
| rx_valid | input | 1 | Receive bit valid |
| rx_ready | output | 1 | Receive ready (always 1) |
| rx_bit | input | 1 | Receive line bit |
| in_sync | output | 1 | Receiver locked to the pattern |

## Verification
Control fields take effect on the edge that samples the write. Load and resync act one edge after that, on the edge that follows the write. A bit accepted on an edge updates `in_sync` and the counters on that same edge, and reads are combinational. The bench drives inputs on falling edges and samples on the next falling edge or later. It keeps `tx_ready` low during register writes and waits one more cycle after each write, so every pulse has landed before the next bits are sent. As a result, counts between two loads equal exactly the number of bits the bench sent. The same-cycle load case is the one exception: there, bits are sent deliberately across the write edges, and the expected split is derived from the edge numbering.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int LFSR_W = 20;

  typedef enum logic [2:0] {
    PAT_P15  = 3'd0,
    PAT_P20  = 3'd1,
    PAT_P11  = 3'd2,
    PAT_P9   = 3'd3,
    PAT_ONES = 3'd4,
    PAT_ALT  = 3'd5,
    PAT_ZA   = 3'd6,
    PAT_ZB   = 3'd7
  } pat_sel_e;

  typedef struct packed {
    logic     tx_inv;
    logic     rx_inv;
    pat_sel_e sel;
  } bert_cfg_t;

  // Next pattern bit predicted from history s (s[0] is the most recent bit).
  function automatic logic pat_expect(pat_sel_e sel, logic [LFSR_W-1:0] s);
    case (sel)
      PAT_P15:  return s[14] ^ s[13];
      PAT_P20:  return s[19] ^ s[16];
      PAT_P11:  return s[10] ^ s[8];
      PAT_P9:   return s[8] ^ s[4];
      PAT_ONES: return 1'b1;
      PAT_ALT:  return ~s[0];
      default:  return 1'b0;
    endcase
  endfunction

  // True when a PRBS history is all zero and would lock up.
  function automatic logic pat_stuck(pat_sel_e sel, logic [LFSR_W-1:0] s);
    case (sel)
      PAT_P15: return s[14:0] == '0;
      PAT_P20: return s[19:0] == '0;
      PAT_P11: return s[10:0] == '0;
      PAT_P9:  return s[8:0] == '0;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bert_patgen.sv
module bert_patgen
  import bert_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  pat_sel_e sel,
  input  logic     invert,
  output logic     bit_o
);
  logic [LFSR_W-1:0] hist_q;
  logic              nxt;

  assign nxt   = pat_expect(sel, hist_q) | pat_stuck(sel, hist_q);
  assign bit_o = nxt ^ invert;

  always_ff @(posedge clk) begin
    if (!rst_n)    hist_q <= '1;
    else if (step) hist_q <= {hist_q[LFSR_W-2:0], nxt};
  end

  AST_GEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(hist_q)); // R5
endmodule

// File: rtl/bert_rxcheck.sv
module bert_rxcheck
  import bert_pkg::*;
#(
  parameter int LOCK_BITS = 32,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic     rx_bit,
  input  pat_sel_e sel,
  input  logic     invert,
  input  logic     resync,
  output logic     in_sync,
  output logic     bit_ev,
  output logic     err_ev
);
  localparam int GW = $clog2(LOCK_BITS);
  localparam int WW = $clog2(WIN_BITS);
  localparam int EW = $clog2(LOSS_ERRS + 1);

  logic [LFSR_W-1:0] hist_q;
  logic              sync_q;
  logic [GW-1:0]     good_q;
  logic [WW-1:0]     win_q;
  logic [EW-1:0]     werr_q;
  logic              data_in, expect_bit, miss, win_last;

  assign data_in    = rx_bit ^ invert;
  assign expect_bit = pat_expect(sel, hist_q);
  assign miss       = data_in != expect_bit;
  assign win_last   = win_q == WW'(WIN_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '1;
      sync_q <= 1'b0;
      good_q <= '0;
      win_q  <= '0;
      werr_q <= '0;
    end else if (resync) begin
      sync_q <= 1'b0;
      good_q <= '0;
      win_q  <= '0;
      werr_q <= '0;
    end else if (beat) begin
      if (!sync_q) begin
        hist_q <= {hist_q[LFSR_W-2:0], data_in};
        if (miss) begin
          good_q <= '0;
        end else if (good_q == GW'(LOCK_BITS - 1)) begin
          sync_q <= 1'b1;
          good_q <= '0;
          win_q  <= '0;
          werr_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        hist_q <= {hist_q[LFSR_W-2:0], expect_bit};
        if (miss && werr_q == EW'(LOSS_ERRS - 1)) begin
          sync_q <= 1'b0;
          good_q <= '0;
          win_q  <= '0;
          werr_q <= '0;
        end else begin
          win_q <= win_last ? '0 : win_q + 1'b1;
          if (win_last)  werr_q <= '0;
          else if (miss) werr_q <= werr_q + 1'b1;
        end
      end
    end
  end

  assign in_sync = sync_q;
  assign bit_ev  = beat & sync_q;
  assign err_ev  = beat & sync_q & miss;

  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !in_sync); // R9
  AST_LOCK_ON_GOOD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(beat) && !$past(miss)); // R7
  AST_LOSS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> $past(resync) || $past(miss)); // R8
endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 bit_ev,
  input  logic                 err_ev,
  output logic [BIT_CNT_W-1:0] hold_bits,
  output logic [ERR_CNT_W-1:0] hold_errs
);
  logic [BIT_CNT_W-1:0] bit_cnt_q, hold_bits_q;
  logic [ERR_CNT_W-1:0] err_cnt_q, hold_errs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt_q   <= '0;
      err_cnt_q   <= '0;
      hold_bits_q <= '0;
      hold_errs_q <= '0;
    end else if (load) begin
      hold_bits_q <= bit_cnt_q;
      hold_errs_q <= err_cnt_q;
      bit_cnt_q   <= BIT_CNT_W'(bit_ev);
      err_cnt_q   <= ERR_CNT_W'(err_ev);
    end else begin
      if (bit_ev && !(&bit_cnt_q)) bit_cnt_q <= bit_cnt_q + 1'b1;
      if (err_ev && !(&err_cnt_q)) err_cnt_q <= err_cnt_q + 1'b1;
    end
  end

  assign hold_bits = hold_bits_q;
  assign hold_errs = hold_errs_q;

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_bits) && $stable(hold_errs)); // R13
  AST_BITS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> bit_cnt_q >= $past(bit_cnt_q)); // R12
  AST_ERRS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> err_cnt_q >= $past(err_cnt_q)); // R12
endmodule

// File: rtl/bert_regs.sv
module bert_regs
  import bert_pkg::*;
#(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [BIT_CNT_W-1:0] hold_bits,
  input  logic [ERR_CNT_W-1:0] hold_errs,
  output bert_cfg_t            cfg,
  output logic                 load_pulse,
  output logic                 resync_pulse
);
  localparam int BIT_BYTES = BIT_CNT_W / 8;
  localparam int ERR_BYTES = ERR_CNT_W / 8;
  localparam int BIT_BASE  = 1;
  localparam int ERR_BASE  = BIT_BASE + BIT_BYTES;

  bert_cfg_t cfg_q;
  logic      lc_q, rs_q, load_q, resync_q, ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      lc_q     <= 1'b0;
      rs_q     <= 1'b0;
      load_q   <= 1'b0;
      resync_q <= 1'b0;
    end else if (ctrl_wr) begin
      cfg_q.tx_inv <= reg_wdata[6];
      cfg_q.rx_inv <= reg_wdata[5];
      cfg_q.sel    <= pat_sel_e'(reg_wdata[4:2]);
      lc_q         <= reg_wdata[1];
      rs_q         <= reg_wdata[0];
      load_q       <= reg_wdata[1] & ~lc_q;
      resync_q     <= reg_wdata[0] & ~rs_q;
    end else begin
      load_q   <= 1'b0;
      resync_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == '0)
      reg_rdata = {1'b0, cfg_q.tx_inv, cfg_q.rx_inv, cfg_q.sel, lc_q, rs_q};
    for (int i = 0; i < BIT_BYTES; i++)
      if (reg_addr == ADDR_W'(BIT_BASE + i)) reg_rdata = hold_bits[8*i +: 8];
    for (int i = 0; i < ERR_BYTES; i++)
      if (reg_addr == ADDR_W'(ERR_BASE + i)) reg_rdata = hold_errs[8*i +: 8];
  end

  assign cfg          = cfg_q;
  assign load_pulse   = load_q;
  assign resync_pulse = resync_q;

  AST_CTRL_SEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> cfg.sel == $past(reg_wdata[4:2])); // R2
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R11
  AST_RESYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse); // R9
endmodule

// File: rtl/bert_engine.sv
module bert_engine
  import bert_pkg::*;
#(
  parameter int BIT_CNT_W = 32,
  parameter int ERR_CNT_W = 24,
  parameter int ADDR_W    = 3,
  parameter int LOCK_BITS = 32,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_bit,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_bit,
  output logic              in_sync
);
  bert_cfg_t            cfg;
  logic                 load_pulse, resync_pulse, bit_ev, err_ev, tx_valid_q;
  logic [BIT_CNT_W-1:0] hold_bits;
  logic [ERR_CNT_W-1:0] hold_errs;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_valid_q <= 1'b0;
    else        tx_valid_q <= 1'b1;
  end
  assign tx_valid = tx_valid_q;
  assign rx_ready = 1'b1;

  bert_regs #(.BIT_CNT_W(BIT_CNT_W), .ERR_CNT_W(ERR_CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hold_bits(hold_bits),
    .hold_errs(hold_errs), .cfg(cfg), .load_pulse(load_pulse),
    .resync_pulse(resync_pulse)
  );

  bert_patgen u_gen (
    .clk(clk), .rst_n(rst_n), .step(tx_valid_q & tx_ready), .sel(cfg.sel),
    .invert(cfg.tx_inv), .bit_o(tx_bit)
  );

  bert_rxcheck #(.LOCK_BITS(LOCK_BITS), .WIN_BITS(WIN_BITS), .LOSS_ERRS(LOSS_ERRS)) u_chk (
    .clk(clk), .rst_n(rst_n), .beat(rx_valid & rx_ready), .rx_bit(rx_bit),
    .sel(cfg.sel), .invert(cfg.rx_inv), .resync(resync_pulse),
    .in_sync(in_sync), .bit_ev(bit_ev), .err_ev(err_ev)
  );

  bert_counters #(.BIT_CNT_W(BIT_CNT_W), .ERR_CNT_W(ERR_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_pulse), .bit_ev(bit_ev),
    .err_ev(err_ev), .hold_bits(hold_bits), .hold_errs(hold_errs)
  );

  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !reg_wr |=> $stable(tx_bit) && tx_valid); // R5
endmodule

// File: tb/bert_engine_bench.sv
module bert_engine_bench;
  localparam int BW = 16;
  localparam int EWD = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          tx_valid, tx_bit, rx_valid, rx_ready, rx_bit, in_sync;
  logic          tx_ready = 1'b0;
  logic          inj = 1'b0;

  assign rx_valid = tx_valid & tx_ready;
  assign rx_bit   = tx_bit ^ inj;

  bert_engine #(.BIT_CNT_W(BW), .ERR_CNT_W(EWD), .ADDR_W(AW)) u_bert_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit(tx_bit), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_bit(rx_bit), .in_sync(in_sync)
  );

  int   checks = 0;
  int   fails = 0;
  logic [7:0] ctrl = 8'h00;
  logic hist [256];

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = '0; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    ctrl = d;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic counts(output int b, output int e);
    logic [7:0] lo, hi, er;
    rd(1, lo); rd(2, hi); rd(3, er);
    b = {hi, lo};
    e = er;
  endtask

  task automatic snap();
    wr(ctrl & 8'hFD);
    wr(ctrl | 8'h02);
  endtask

  task automatic force_rs();
    wr(ctrl & 8'hFE);
    wr(ctrl | 8'h01);
  endtask

  task automatic run(input int n, input int period, input int burst, input bit rec);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_ready = 1'b1;
      inj = ((period != 0) && (i % period == period - 1)) || (i < burst);
      if (rec && i < 256) begin
        #1 hist[i] = tx_bit;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    inj = 1'b0;
  endtask

  task automatic chk_pattern(input int sel, input bit tinv, input int len);
    int bad = 0;
    int ones = 0;
    int n = 0;
    int k = 0;
    case (sel)
      0: begin n = 15; k = 14; end
      1: begin n = 20; k = 17; end
      2: begin n = 11; k = 9; end
      3: begin n = 9;  k = 5; end
      default: ;
    endcase
    for (int i = 0; i < len; i++) begin
      logic b;
      b = hist[i] ^ tinv;
      if (b) ones++;
      if (n != 0) begin
        if (i >= n && b != ((hist[i-n] ^ tinv) ^ (hist[i-k] ^ tinv))) bad++;
      end else if (sel == 4) begin
        if (b != 1'b1) bad++;
      end else if (sel == 5) begin
        if (i > 0 && b == (hist[i-1] ^ tinv)) bad++;
      end else begin
        if (b != 1'b0) bad++;
      end
    end
    if (n != 0 && ones == 0) bad++;
    check(bad == 0, $sformatf("R3/R4 pattern sel=%0d tinv=%0d bad bits", sel, tinv), bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int b, e, b2, e2;
    logic t0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, d);
      check(d == 8'h00, $sformatf("R1 reset read addr %0d", a), d, 0);
    end
    check(in_sync == 1'b0, "R1 in_sync after reset", in_sync, 0);
    check(tx_valid == 1'b1 && rx_ready == 1'b1, "R1 tx_valid/rx_ready", {tx_valid, rx_ready}, 3);

    // R3 R4 R6 sweep over every pattern select with both inversion settings
    for (int sel = 0; sel < 8; sel++) begin
      for (int ti = 0; ti < 2; ti++) begin
        wr({1'b0, ti[0], ti[0], sel[2:0], 2'b00});
        run(120, 0, 0, 1'b0);
        run(220, 0, 0, 1'b1);
        chk_pattern(sel, ti[0], 220);
        check(in_sync == 1'b1, $sformatf("R6 matched inversion lock sel=%0d", sel), in_sync, 1);
      end
    end

    // R2 readback, bit 7 always 0
    wr(8'hF4);
    rd(0, d);
    check(d == 8'h74, "R2 control readback", d, 8'h74);

    // R6 R10 mismatched receive inversion never locks, nothing counted
    wr(8'h20);
    force_rs();
    snap();
    run(300, 0, 0, 1'b0);
    check(in_sync == 1'b0, "R6 mismatched inversion stays unlocked", in_sync, 0);
    snap();
    counts(b, e);
    check(b == 0 && e == 0, "R10 no counting out of sync", b + e, 0);

    // R5 transmit hold under back-pressure
    wr(8'h00);
    run(100, 0, 0, 1'b0);
    @(negedge clk);
    t0 = tx_bit;
    repeat (5) @(negedge clk);
    check(tx_bit == t0 && tx_valid, "R5 tx_bit held while not ready", tx_bit, t0);

    // R7 R9 forced resync and exact relock
    wr(8'h04);
    run(150, 0, 0, 1'b0);
    check(in_sync == 1'b1, "R7 locked on 20-stage PRBS", in_sync, 1);
    force_rs();
    check(in_sync == 1'b0, "R9 resync edge drops lock", in_sync, 0);
    run(31, 0, 0, 1'b0);
    check(in_sync == 1'b0, "R7 not locked after 31 bits", in_sync, 0);
    run(1, 0, 0, 1'b0);
    check(in_sync == 1'b1, "R7 locked on 32nd bit", in_sync, 1);
    wr(ctrl);
    check(in_sync == 1'b1, "R9 resync held high has no effect", in_sync, 1);

    // R8 loss threshold inside a window starting at lock
    force_rs();
    run(32, 0, 0, 1'b0);
    run(64, 0, 5, 1'b0);
    check(in_sync == 1'b1, "R8 five errors keep lock", in_sync, 1);
    run(5, 0, 5, 1'b0);
    check(in_sync == 1'b1, "R8 five errors in new window keep lock", in_sync, 1);
    run(1, 0, 1, 1'b0);
    check(in_sync == 1'b0, "R8 sixth error drops lock", in_sync, 0);
    run(100, 0, 0, 1'b0);

    // R10 R11 R13 exact counts and snapshot behaviour
    snap();
    run(500, 20, 0, 1'b0);
    snap();
    counts(b, e);
    check(b == 500, "R10 bit count", b, 500);
    check(e == 25, "R10 error count", e, 25);
    counts(b2, e2);
    check(b2 == b && e2 == e, "R13 reads have no side effect", b2, b);
    run(7, 0, 0, 1'b0);
    wr(ctrl);
    counts(b2, e2);
    check(b2 == 500 && e2 == 25, "R11 load held high does not reload", b2, 500);

    // R11 bit accepted on the load edge lands in the cleared counter
    wr(ctrl & 8'hFD);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = ctrl | 8'h02; tx_ready = 1'b1;
    @(negedge clk);
    reg_wdata = ctrl & 8'hFD;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (10) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = ctrl | 8'h02;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    tx_ready = 1'b0;
    ctrl = ctrl | 8'h02;
    counts(b, e);
    check(b == 12, "R11 count between back-to-back loads", b, 12);
    snap();
    counts(b, e);
    check(b == 1, "R11 same-cycle bit kept", b, 1);

    // R12 saturation of both counters
    snap();
    run(70000, 13, 0, 1'b0);
    snap();
    counts(b, e);
    check(b == 65535, "R12 bit counter saturates", b, 65535);
    check(e == 255, "R12 error counter saturates", e, 255);
    check(in_sync == 1'b1, "R8 spaced errors keep lock", in_sync, 1);

    summary();
    $finish;
  end
endmodule